// File: doc/BRIEF.md
# Clock-Chip Watchdog and Software Reset Controller

This block supervises a system through a watchdog timer held in the control registers of a clock chip. Software writes a 3-bit timeout code. Codes 1 to 7 arm a counter that advances on a reference tick. If software does not rewrite the code before the selected interval runs out, the block sets a sticky alarm bit. Writing any nonzero code restarts the interval, so software kicks the watchdog by writing its code again. Writing code 0 clears the alarm and parks the counter, because that code is kept for test use and never expires. When the autorecovery input is high, each timeout also raises a one-cycle strobe that the surrounding logic can use to restore its default state.

The same block owns a self-clearing software reset bit. Writing that bit drives an active-low reset output low for a fixed number of clock cycles. The bit still reads 1 on the cycle after the output is released, and it clears to 0 one cycle later. The reset output works only when an enable strap was sampled high on the rising edge of power-good. Register writes arrive as single-cycle strobes.

Top module: `wdog_ctrl_top`

## Requirements
- R1: While `rst_n` is low and after its release, `wd_code` is 0, `wd_alarm` is 0, `wd_recover` is 0, `swrst_bit` is 0 and `swrst_out_n` is 1.
- R2: With code n (1 to 7) stored, `wd_alarm` goes to 1 on the clock edge of the (n × TIME_SCALE)-th `ref_tick` counted since the code was written, and not before.
- R3: `wd_alarm` stays 1 until a write of code 0. Writing a nonzero code leaves it set.
- R4: With code 0 stored, no number of ticks sets `wd_alarm` or `wd_recover`.
- R5: Writing a nonzero code restarts the count from zero, so rewriting the same code works as a kick.
- R6: When a code write and the tick that would expire the interval fall in the same cycle, the write wins. No alarm is raised and the count restarts.
- R7: If `autorec_en` is 1 when a timeout occurs, `wd_recover` is 1 for exactly the one cycle in which `wd_alarm` is first set. If `autorec_en` is 0, `wd_recover` stays 0.
- R8: A `swrst_wr` strobe accepted at edge E0 drives `swrst_out_n` low from E0 for RST_PULSE_W cycles. `swrst_bit` is 1 from E0 through the first cycle after release, then returns to 0.
- R9: If the strap was latched 0, `swrst_wr` has no effect: `swrst_out_n` stays 1 and `swrst_bit` stays 0.
- R10: `rst_en_strap` is sampled only on a rising edge of `pwr_good`. Later changes of the strap have no effect until the next rising edge.
- R11: A `swrst_wr` strobe that arrives while a pulse is in progress is ignored, and the pulse does not get longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rising edge latches the strap |
| rst_en_strap | input | 1 | Enable strap for the software reset output |
| ref_tick | input | 1 | One-cycle reference tick that advances the watchdog |
| wd_wr | input | 1 | Write strobe for the timeout code |
| wd_wdata | input | 3 | Timeout code to write |
| autorec_en | input | 1 | Autorecovery mode enable |
| swrst_wr | input | 1 | Strobe that sets the software reset bit |
| wd_code | output | 3 | Stored timeout code |
| wd_alarm | output | 1 | Sticky timeout alarm |
| wd_recover | output | 1 | One-cycle recover strobe on timeout in autorecovery mode |
| swrst_bit | output | 1 | Readback of the self-clearing software reset bit |
| swrst_out_n | output | 1 | Active-low software reset output |

## Verification
The two watchdog functions that can collide are a software kick and the expiring tick. They can land in the same cycle when a code write is strobed together with the tick that would finish the interval. The bench provokes this by counting ticks up to one short of the interval and then driving the write and the final tick together. It judges the result by seeing no alarm on that edge and by seeing the alarm only after a full fresh interval. A second overlap is a software reset write that arrives during an active pulse. The bench checks that the release still comes at the original cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,
    SR_LOW  = 2'd1,
    SR_HOLD = 2'd2
  } swrst_state_e;

  // Number of reference ticks a code allows before timing out (0: never).
  function automatic int unsigned limit_ticks(input logic [2:0] code,
                                              input int unsigned scale);
    return 32'(code) * scale;
  endfunction

  // True when the tick about to be counted completes the interval.
  function automatic logic is_last_tick(input int unsigned cnt_now,
                                        input logic [2:0] code,
                                        input int unsigned scale);
    return (code != 3'd0) && (cnt_now + 32'd1 == limit_ticks(code, scale));
  endfunction

endpackage

// File: rtl/wdog_strap_latch.sv
module wdog_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic strap_in,
  output logic strap_q
);
  logic pg_d;
  logic pg_rise;

  assign pg_rise = pwr_good && !pg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_d    <= 1'b0;
      strap_q <= 1'b0;
    end else begin
      pg_d <= pwr_good;
      if (pg_rise) strap_q <= strap_in;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned TIME_SCALE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       code_wr,
  input  logic [2:0] code_wdata,
  input  logic       autorec_en,
  output logic [2:0] code_q,
  output logic       alarm,
  output logic       recover,
  output logic       expire
);
  localparam int unsigned MAX_TICKS = 7 * TIME_SCALE;
  localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;

  // A timeout only counts if no write lands in the same cycle.
  always_comb begin
    expire = tick && !code_wr && is_last_tick(32'(cnt), code_q, TIME_SCALE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= 3'd0;
      cnt     <= '0;
      alarm   <= 1'b0;
      recover <= 1'b0;
    end else begin
      recover <= expire && autorec_en;
      if (code_wr) begin
        code_q <= code_wdata;
        cnt    <= '0;
        if (code_wdata == 3'd0) alarm <= 1'b0;
      end else if (expire) begin
        cnt   <= '0;
        alarm <= 1'b1;
      end else if (tick && code_q != 3'd0) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_swrst_gen.sv
module wdog_swrst_gen
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wr,
  input  logic enable,
  output logic bit_q,
  output logic out_n,
  output logic accept
);
  localparam int unsigned PW_W = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  swrst_state_e  state;
  logic [PW_W-1:0] pcnt;

  assign accept = (state == SR_IDLE) && set_wr && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SR_IDLE;
      pcnt  <= '0;
      bit_q <= 1'b0;
      out_n <= 1'b1;
    end else begin
      unique case (state)
        SR_IDLE: begin
          if (accept) begin
            state <= SR_LOW;
            pcnt  <= PW_W'(PULSE_W - 1);
            bit_q <= 1'b1;
            out_n <= 1'b0;
          end
        end
        SR_LOW: begin
          if (pcnt == '0) begin
            out_n <= 1'b1;
            state <= SR_HOLD;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        SR_HOLD: begin
          bit_q <= 1'b0;
          state <= SR_IDLE;
        end
        default: state <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdog_ctrl_top.sv
module wdog_ctrl_top #(
  parameter int unsigned TIME_SCALE  = 16,
  parameter int unsigned RST_PULSE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       rst_en_strap,
  input  logic       ref_tick,
  input  logic       wd_wr,
  input  logic [2:0] wd_wdata,
  input  logic       autorec_en,
  input  logic       swrst_wr,
  output logic [2:0] wd_code,
  output logic       wd_alarm,
  output logic       wd_recover,
  output logic       swrst_bit,
  output logic       swrst_out_n
);
  // Internal events named for the checker.
  logic strap_q;
  logic wd_expire;
  logic swrst_accept;

  wdog_strap_latch u_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .strap_in (rst_en_strap),
    .strap_q  (strap_q)
  );

  wdog_timer #(.TIME_SCALE(TIME_SCALE)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (ref_tick),
    .code_wr    (wd_wr),
    .code_wdata (wd_wdata),
    .autorec_en (autorec_en),
    .code_q     (wd_code),
    .alarm      (wd_alarm),
    .recover    (wd_recover),
    .expire     (wd_expire)
  );

  wdog_swrst_gen #(.PULSE_W(RST_PULSE_W)) u_swrst (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (swrst_wr),
    .enable (strap_q),
    .bit_q  (swrst_bit),
    .out_n  (swrst_out_n),
    .accept (swrst_accept)
  );
endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wd_wr,
  input logic [2:0] wd_wdata,
  input logic       autorec_en,
  input logic [2:0] wd_code,
  input logic       wd_alarm,
  input logic       wd_recover,
  input logic       wd_expire,
  input logic       strap_q,
  input logic       swrst_bit,
  input logic       swrst_out_n,
  input logic       swrst_accept
);
  // R7
  recover_needs_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_recover |-> wd_alarm);

  // R7
  recover_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_recover) |-> $past(autorec_en));

  // R3
  alarm_clear_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_alarm) |-> $past(wd_wr && wd_wdata == 3'd0));

  // R4
  code_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_code == 3'd0) |-> !wd_expire);

  // R9
  strap_gates_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_q |-> !swrst_accept);

  // R8
  bit_clears_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(swrst_bit) |-> (swrst_out_n && $past(swrst_out_n)));

  // R8
  out_low_means_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swrst_out_n |-> swrst_bit);
endmodule

bind wdog_ctrl_top wdog_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wd_wr        (wd_wr),
  .wd_wdata     (wd_wdata),
  .autorec_en   (autorec_en),
  .wd_code      (wd_code),
  .wd_alarm     (wd_alarm),
  .wd_recover   (wd_recover),
  .wd_expire    (wd_expire),
  .strap_q      (strap_q),
  .swrst_bit    (swrst_bit),
  .swrst_out_n  (swrst_out_n),
  .swrst_accept (swrst_accept)
);

// File: tb/wdog_ctrl_top_tb_top.sv
module wdog_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SCALE      = 4;
  localparam int PW         = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_good, rst_en_strap, ref_tick, wd_wr, autorec_en, swrst_wr;
  logic [2:0] wd_wdata;
  logic [2:0] wd_code;
  logic       wd_alarm, wd_recover, swrst_bit, swrst_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_ctrl_top #(.TIME_SCALE(SCALE), .RST_PULSE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .rst_en_strap(rst_en_strap),
    .ref_tick(ref_tick), .wd_wr(wd_wr), .wd_wdata(wd_wdata),
    .autorec_en(autorec_en), .swrst_wr(swrst_wr), .wd_code(wd_code),
    .wd_alarm(wd_alarm), .wd_recover(wd_recover), .swrst_bit(swrst_bit),
    .swrst_out_n(swrst_out_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_code(input logic [2:0] c);
    wd_wr = 1'b1; wd_wdata = c;
    cyc(1);
    wd_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    ref_tick = 1'b1;
    cyc(n);
    ref_tick = 1'b0;
  endtask

  task automatic t_reset;
    check(wd_alarm == 0 && wd_recover == 0 && wd_code == 0, "R1 wdog", wd_alarm, 0);
    check(swrst_bit == 0 && swrst_out_n == 1, "R1 swrst", swrst_out_n, 1);
  endtask

  task automatic t_timeout(input logic [2:0] c);
    int lim = int'(c) * SCALE;
    write_code(3'd0);
    write_code(c);
    ticks(lim - 1);
    check(wd_alarm == 0, "R2 early", wd_alarm, 0);
    ticks(1);
    check(wd_alarm == 1, "R2 expire", wd_alarm, 1);
    check(wd_recover == 0, "R7 no autorec", wd_recover, 0);
    write_code(3'd5);
    check(wd_alarm == 1, "R3 nonzero keeps", wd_alarm, 1);
    write_code(3'd0);
    check(wd_alarm == 0, "R3 zero clears", wd_alarm, 0);
  endtask

  task automatic t_kick;
    write_code(3'd2);
    ticks(2*SCALE - 2);
    write_code(3'd2);
    ticks(2*SCALE - 1);
    check(wd_alarm == 0, "R5 kick restarts", wd_alarm, 0);
    ticks(1);
    check(wd_alarm == 1, "R5 full interval", wd_alarm, 1);
    write_code(3'd0);
  endtask

  task automatic t_code_zero;
    write_code(3'd0);
    ticks(100);
    check(wd_alarm == 0 && wd_recover == 0, "R4 code zero", wd_alarm, 0);
  endtask

  task automatic t_autorec;
    autorec_en = 1'b1;
    write_code(3'd1);
    ticks(SCALE);
    check(wd_recover == 1 && wd_alarm == 1, "R7 strobe", wd_recover, 1);
    cyc(1);
    check(wd_recover == 0, "R7 one cycle", wd_recover, 0);
    autorec_en = 1'b0;
    write_code(3'd0);
  endtask

  task automatic t_collision;
    write_code(3'd1);
    ticks(SCALE - 1);
    ref_tick = 1'b1; wd_wr = 1'b1; wd_wdata = 3'd1;
    cyc(1);
    ref_tick = 1'b0; wd_wr = 1'b0;
    check(wd_alarm == 0, "R6 write wins", wd_alarm, 0);
    ticks(SCALE - 1);
    check(wd_alarm == 0, "R6 restarted", wd_alarm, 0);
    ticks(1);
    check(wd_alarm == 1, "R6 later expire", wd_alarm, 1);
    write_code(3'd0);
  endtask

  task automatic t_strap_off;
    swrst_wr = 1'b1;
    cyc(1);
    swrst_wr = 1'b0;
    for (int i = 0; i < PW + 2; i++) begin
      check(swrst_out_n == 1 && swrst_bit == 0, "R9 ignored", swrst_out_n, 1);
      cyc(1);
    end
    // strap goes high without a power-good edge
    rst_en_strap = 1'b1;
    cyc(2);
    swrst_wr = 1'b1;
    cyc(1);
    swrst_wr = 1'b0;
    check(swrst_out_n == 1 && swrst_bit == 0, "R10 no edge", swrst_out_n, 1);
  endtask

  task automatic t_swrst_pulse;
    pwr_good = 1'b0;
    cyc(2);
    pwr_good = 1'b1;
    cyc(2);
    rst_en_strap = 1'b0;  // later change must not matter
    cyc(1);
    swrst_wr = 1'b1;
    cyc(1);
    swrst_wr = 1'b0;
    for (int i = 0; i < PW; i++) begin
      check(swrst_out_n == 0 && swrst_bit == 1, "R8 low", swrst_out_n, 0);
      if (i == 0) swrst_wr = 1'b1;  // R11: extra write during pulse
      cyc(1);
      swrst_wr = 1'b0;
    end
    check(swrst_out_n == 1 && swrst_bit == 1, "R11 R8 release", swrst_out_n, 1);
    cyc(1);
    check(swrst_bit == 0 && swrst_out_n == 1, "R8 self clear", swrst_bit, 0);
    cyc(PW + 2);
    check(swrst_out_n == 1, "R11 no re-trigger", swrst_out_n, 1);
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; rst_en_strap = 1'b0; ref_tick = 1'b0;
    wd_wr = 1'b0; wd_wdata = 3'd0; autorec_en = 1'b0; swrst_wr = 1'b0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    pwr_good = 1'b1;  // latches strap 0
    cyc(2);
    t_timeout(3'd1);
    t_timeout(3'd3);
    t_timeout(3'd7);
    t_kick();
    t_code_zero();
    t_autorec();
    t_collision();
    t_strap_off();
    t_swrst_pulse();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule